// File: doc/BRIEF.md
# Configurable K-Best Tree-Level Center Calculator

This block forms the search center for one tree level of a real-valued breadth-first MIMO detector. For every surviving path, the center is the level's received estimate minus a weighted sum of the decision offsets (chosen symbol minus its estimate) of the levels already decided. The weights are channel ratios that are computed once per channel realization. They are loaded through a small coefficient write port, so the block needs no divider.

Deeper tree levels need more product terms. For this reason, the multipliers form one shared pool of lanes, and the lanes are split into groups. Each group's partial sum passes through a chain of one-input, two-output steering muxes, and a per-vector configuration word decides which detector cell receives that partial sum. A cell that owns several groups gets their partial sums added together, so one datapath serves cells working on levels of different depth. A valid/ready stream carries one path per beat and delivers one set of centers per clock.

A small controller has two states. `ST_IDLE` means no vector is open. `ST_VEC` means a vector is open and its configuration is frozen. The transitions are:
- START: a non-last beat is accepted in `ST_IDLE`, which moves the controller to `ST_VEC`.
- SINGLE: a last beat is accepted in `ST_IDLE`, and the controller stays in `ST_IDLE`.
- END: a last beat is accepted in `ST_VEC`, which moves the controller to `ST_IDLE`.

Top module: `kbc_center_calc`

## Requirements
- R1: For each cell c, `center = sat(est_c − Σ term_m)`. The sum runs over every lane m whose group is routed to cell c. All values are signed fixed point with 7 integer and 7 fraction bits (14 bits).
- R2: A lane term is computed in three steps. First, `d = sat(sym − shat)`. Second, the product `coef·d` is rounded to 7 fraction bits by adding 64 and shifting right arithmetically by 7, which rounds half up. Third, the result is saturated to 14 bits.
- R3: The center saturates to the range [−8192, 8191] and never wraps.
- R4: Group g uses the lanes g·2 and g·2+1. Its owner code sits in bits [2g+1:2g] of `cfg_i`. Code 0 routes the group to cell 0, code 1 to cell 1, and codes 2 and 3 to cell 2. A cell that owns no group outputs its estimate unchanged.
- R5: A write with `coef_we` high stores `coef_wdata` into lane `coef_addr`. Beats accepted after the write cycle use the new value. A write made while a vector is open (`ST_VEC`) is ignored.
- R6: The configuration is taken from `cfg_i` on the first beat of a vector and is held until the beat with `in_last` high has been accepted. Any change to `cfg_i` in between has no effect.
- R7: A beat that is accepted while `out_ready` stays high appears on `out_valid`/`center_o` two clock edges later. Beats can be accepted back to back, one per clock.
- R8: While `out_valid` is high and `out_ready` is low, `center_o` holds its value and `in_ready` is low.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, every coefficient is 0 (so the center equals the estimate), and the controller is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Lane index to write |
| coef_wdata | input | 14 | Channel ratio in 7.7 format |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| in_last | input | 1 | Marks the last path of a vector |
| cfg_i | input | 6 | Group owner codes, 2 bits per group |
| est_i | input | 42 | Per-cell level estimates, cell c in bits [14c+13:14c] |
| sym_i | input | 84 | Chosen symbols of earlier levels, one per lane |
| shat_i | input | 84 | Estimates of earlier levels, one per lane |
| out_valid | output | 1 | Centers valid |
| out_ready | input | 1 | Downstream accepts centers |
| center_o | output | 42 | Per-cell centers, same layout as `est_i` |

## Verification
Every result is due exactly two clock edges after its acceptance edge: one edge for the lane register and one for the output register. The bench notes the cycle count at the falling edge on which each beat is offered with `in_ready` high, and it expects the matching center at the falling edge two cycles later. It compares the data only at falling-edge sample points where `out_valid` and `out_ready` are both high, so the order of processes at a clock edge cannot affect the result. During back-pressure the latency check is switched off. Instead, the bench samples the held output on several consecutive falling edges.

// File: rtl/kbc_pkg.sv
`timescale 1ns/1ps
package kbc_pkg;

    // Width used for all intermediate arithmetic before saturation.
    localparam int WIDE = 48;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_VEC  = 1'b1
    } kbc_state_e;

    // Clip a wide signed value to the range of a w-bit signed number.
    function automatic logic signed [WIDE-1:0] sat_wide(
        input logic signed [WIDE-1:0] v,
        input int                     w
    );
        logic signed [WIDE-1:0] hi;
        logic signed [WIDE-1:0] lo;
        hi = (WIDE'(1) <<< (w - 1)) - WIDE'(1);
        lo = ~hi;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/kbc_mul_lane.sv
`timescale 1ns/1ps
module kbc_mul_lane
    import kbc_pkg::*;
#(
    parameter int DW   = 14,
    parameter int FRAC = 7
) (
    input  logic signed [DW-1:0] coef,
    input  logic signed [DW-1:0] sym,
    input  logic signed [DW-1:0] shat,
    output logic signed [DW-1:0] term
);

    localparam logic signed [WIDE-1:0] HALF = WIDE'(1) <<< (FRAC - 1);

    logic signed [WIDE-1:0] diff_raw;
    logic signed [WIDE-1:0] diff_sat;
    logic signed [WIDE-1:0] prod;
    logic signed [WIDE-1:0] rounded;

    always_comb begin
        // Decision offset, clipped to the fixed-point range.
        diff_raw = WIDE'(sym) - WIDE'(shat);
        diff_sat = sat_wide(diff_raw, DW);
        // Full-precision product, round half up, back to 7.7.
        prod     = WIDE'(coef) * diff_sat;
        rounded  = (prod + HALF) >>> FRAC;
        term     = DW'(sat_wide(rounded, DW));
    end

endmodule

// File: rtl/kbc_steer.sv
`timescale 1ns/1ps
module kbc_steer #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         sel,
    output logic [W-1:0] out_hi,
    output logic [W-1:0] out_lo
);

    // One input, two outputs: select high feeds out_hi, low feeds out_lo.
    always_comb begin
        if (sel) begin
            out_hi = din;
            out_lo = '0;
        end else begin
            out_hi = '0;
            out_lo = din;
        end
    end

endmodule

// File: rtl/kbc_route.sv
`timescale 1ns/1ps
module kbc_route #(
    parameter int W     = 16,
    parameter int NCELL = 3,
    parameter int OW    = 2
) (
    input  logic [W-1:0]       din,
    input  logic [OW-1:0]      owner,
    output logic [NCELL*W-1:0] dout
);

    // carry[c] is the value still travelling down the chain at stage c.
    logic [W-1:0] carry [NCELL];

    assign carry[0] = din;

    for (genvar c = 0; c < NCELL - 1; c++) begin : g_stage
        logic [W-1:0] hi_out;
        kbc_steer #(.W(W)) u_steer (
            .din    (carry[c]),
            .sel    (owner == OW'(c)),
            .out_hi (hi_out),
            .out_lo (carry[c+1])
        );
        assign dout[c*W +: W] = hi_out;
    end

    // The final cell takes whatever no earlier stage claimed.
    assign dout[(NCELL-1)*W +: W] = carry[NCELL-1];

endmodule

// File: rtl/kbc_ctrl.sv
`timescale 1ns/1ps
module kbc_ctrl
    import kbc_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          last_i,
    input  logic [CW-1:0] cfg_i,
    output logic          idle_o,
    output logic [CW-1:0] cfg_o
);

    kbc_state_e    state_q;
    kbc_state_e    state_d;
    logic [CW-1:0] cfg_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration captured on the opening beat of a vector.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cfg_q <= '0;
        else if (acc_i && state_q == ST_IDLE)  cfg_q <= cfg_i;
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        idle_o  = 1'b0;
        cfg_o   = cfg_q;
        unique case (state_q)
            ST_IDLE: begin
                idle_o = 1'b1;
                cfg_o  = cfg_i;
                if (acc_i && !last_i) state_d = ST_VEC;     // START
            end
            ST_VEC: begin
                if (acc_i && last_i) state_d = ST_IDLE;     // END
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R6: the captured configuration is frozen while a vector is open.
    a_r6_cfg_frozen: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC) |=> $stable(cfg_q)
    );

    // R6: accepting the closing beat returns the controller to idle.
    a_r6_vec_close: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC && acc_i && last_i) |=> (state_q == ST_IDLE)
    );

endmodule

// File: rtl/kbc_center_calc.sv
`timescale 1ns/1ps
module kbc_center_calc
    import kbc_pkg::*;
#(
    parameter int DW    = 14,
    parameter int FRAC  = 7,
    parameter int NCELL = 3,
    parameter int NGRP  = 3,
    parameter int GSZ   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        coef_we,
    input  logic [$clog2(NGRP*GSZ)-1:0] coef_addr,
    input  logic [DW-1:0]               coef_wdata,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_last,
    input  logic [NGRP*$clog2(NCELL)-1:0] cfg_i,
    input  logic [NCELL*DW-1:0]         est_i,
    input  logic [NGRP*GSZ*DW-1:0]      sym_i,
    input  logic [NGRP*GSZ*DW-1:0]      shat_i,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NCELL*DW-1:0]         center_o
);

    localparam int NLANE = NGRP * GSZ;
    localparam int LW    = $clog2(NLANE);
    localparam int OW    = $clog2(NCELL);
    localparam int CW    = NGRP * OW;
    localparam int SW    = DW + $clog2(NLANE) + 2;

    // ---------------- control ----------------
    logic          pipe_en;
    logic          acc;
    logic          idle;
    logic [CW-1:0] cfg_eff;

    assign pipe_en  = !out_valid || out_ready;
    assign in_ready = pipe_en;
    assign acc      = in_valid && pipe_en;

    kbc_ctrl #(.CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_i  (acc),
        .last_i (in_last),
        .cfg_i  (cfg_i),
        .idle_o (idle),
        .cfg_o  (cfg_eff)
    );

    // ---------------- coefficient store ----------------
    logic signed [DW-1:0] coef_q [NLANE];
    logic [NLANE*DW-1:0]  coef_flat;

    for (genvar m = 0; m < NLANE; m++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                coef_q[m] <= '0;
            else if (coef_we && idle && coef_addr == LW'(m))
                coef_q[m] <= coef_wdata;
        end
        assign coef_flat[m*DW +: DW] = coef_q[m];
    end

    // ---------------- stage 1: multiplier pool ----------------
    logic signed [DW-1:0] lane_term [NLANE];
    logic signed [DW-1:0] s1_term   [NLANE];
    logic                 s1_valid;
    logic [NCELL*DW-1:0]  s1_est;
    logic [CW-1:0]        s1_cfg;

    for (genvar m = 0; m < NLANE; m++) begin : g_lane
        kbc_mul_lane #(.DW(DW), .FRAC(FRAC)) u_lane (
            .coef (coef_q[m]),
            .sym  (sym_i[m*DW +: DW]),
            .shat (shat_i[m*DW +: DW]),
            .term (lane_term[m])
        );
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       s1_term[m] <= '0;
            else if (pipe_en) s1_term[m] <= lane_term[m];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_est   <= '0;
            s1_cfg   <= '0;
        end else if (pipe_en) begin
            s1_valid <= in_valid;
            s1_est   <= est_i;
            s1_cfg   <= cfg_eff;
        end
    end

    // ---------------- stage 2: group sums, steering, cell sums ----------------
    logic [NCELL*SW-1:0] routed [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic signed [SW-1:0] gsum;
        logic [NCELL-1:0]     nz;

        always_comb begin
            gsum = '0;
            for (int k = 0; k < GSZ; k++)
                gsum = gsum + SW'(s1_term[g*GSZ + k]);
        end

        kbc_route #(.W(SW), .NCELL(NCELL), .OW(OW)) u_route (
            .din   (gsum),
            .owner (s1_cfg[g*OW +: OW]),
            .dout  (routed[g])
        );

        always_comb begin
            for (int c = 0; c < NCELL; c++)
                nz[c] = (routed[g][c*SW +: SW] != '0);
        end

        // R4: a group's partial sum reaches at most one cell.
        a_r4_single_dest: assert property (
            @(posedge clk) disable iff (!rst_n)
            $countones(nz) <= 1
        );
    end

    logic signed [SW-1:0]   csum  [NCELL];
    logic [NCELL*DW-1:0]    center_d;
    logic [NCELL*DW-1:0]    center_q;

    always_comb begin
        for (int c = 0; c < NCELL; c++) begin
            csum[c] = '0;
            for (int g = 0; g < NGRP; g++)
                csum[c] = csum[c] + $signed(routed[g][c*SW +: SW]);
            center_d[c*DW +: DW] = DW'(sat_wide(
                WIDE'($signed(s1_est[c*DW +: DW])) - WIDE'(csum[c]), DW));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            center_q  <= '0;
        end else if (pipe_en) begin
            out_valid <= s1_valid;
            center_q  <= center_d;
        end
    end

    assign center_o = center_q;

    // ---------------- assertions ----------------
    // R8: a stalled result holds its value.
    a_r8_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(center_o))
    );

    // R8: no beat is taken while the output is stalled.
    a_r8_no_accept: assert property (
        @(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready
    );

    // R7: an accepted beat reaches the lane register on the next edge.
    a_r7_stage_fill: assert property (
        @(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_valid
    );

    // R7: a filled lane register reaches the output when the pipe moves.
    a_r7_out_fill: assert property (
        @(posedge clk) disable iff (!rst_n)
        (s1_valid && pipe_en) |=> out_valid
    );

    // R5: coefficients cannot change while a vector is open.
    a_r5_coef_frozen: assert property (
        @(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(coef_flat)
    );

endmodule

// File: tb/kbc_center_calc_bench.sv
`timescale 1ns/1ps
module kbc_center_calc_bench;

    localparam int DW    = 14;
    localparam int FRAC  = 7;
    localparam int NCELL = 3;
    localparam int NGRP  = 3;
    localparam int GSZ   = 2;
    localparam int NLANE = NGRP * GSZ;
    localparam int LW    = 3;
    localparam int CW    = 6;
    localparam int QD    = 1024;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 coef_we = 1'b0;
    logic [LW-1:0]        coef_addr = '0;
    logic [DW-1:0]        coef_wdata = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic                 in_last = 1'b0;
    logic [CW-1:0]        cfg_v = '0;
    logic [NCELL*DW-1:0]  est_v = '0;
    logic [NLANE*DW-1:0]  sym_v = '0;
    logic [NLANE*DW-1:0]  shat_v = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [NCELL*DW-1:0]  center_o;

    kbc_center_calc #(
        .DW(DW), .FRAC(FRAC), .NCELL(NCELL), .NGRP(NGRP), .GSZ(GSZ)
    ) u_kbc_center_calc (
        .clk(clk), .rst_n(rst_n),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .cfg_i(cfg_v), .est_i(est_v), .sym_i(sym_v), .shat_i(shat_v),
        .out_valid(out_valid), .out_ready(out_ready), .center_o(center_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Bench model state.
    int coef_m [NLANE];
    int est_m  [NCELL];
    int sym_m  [NLANE];
    int shat_m [NLANE];
    int cfg_m   = 0;
    int cfg_lat = 0;
    bit m_idle  = 1'b1;

    // Expectation queue.
    int    exp_c  [QD][NCELL];
    int    exp_cy [QD];
    bit    exp_lat[QD];
    string exp_r  [QD];
    int    wp = 0;
    int    rp = 0;

    function automatic int sat14(int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int lane_val(int c, int s, int h);
        int d;
        int p;
        d = sat14(s - h);
        p = c * d;
        return sat14((p + 64) >>> 7);
    endfunction

    function automatic int dest(int code, int g);
        int f;
        f = (code >> (2 * g)) & 3;
        return (f >= 2) ? 2 : f;
    endfunction

    task automatic check(bit ok, string r, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, expv);
        end
    endtask

    task automatic drive_inputs();
        for (int c = 0; c < NCELL; c++) est_v[c*DW +: DW] = 14'(est_m[c]);
        for (int m = 0; m < NLANE; m++) begin
            sym_v[m*DW +: DW]  = 14'(sym_m[m]);
            shat_v[m*DW +: DW] = 14'(shat_m[m]);
        end
        cfg_v = 6'(cfg_m);
    endtask

    task automatic push_exp(string r, bit lat);
        int sum;
        if (m_idle) cfg_lat = cfg_m;
        for (int c = 0; c < NCELL; c++) begin
            sum = 0;
            for (int g = 0; g < NGRP; g++)
                if (dest(cfg_lat, g) == c)
                    for (int k = 0; k < GSZ; k++)
                        sum += lane_val(coef_m[g*GSZ+k], sym_m[g*GSZ+k], shat_m[g*GSZ+k]);
            exp_c[wp % QD][c] = sat14(est_m[c] - sum);
        end
        exp_cy[wp % QD]  = cyc + 2;
        exp_lat[wp % QD] = lat;
        exp_r[wp % QD]   = r;
        wp++;
    endtask

    // Offer one beat; returns at the falling edge after it is taken.
    task automatic send(bit last, string r, bit lat);
        drive_inputs();
        in_last  = last;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        push_exp(r, lat);
        m_idle = last;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr_coef(int lane, int val);
        coef_we    = 1'b1;
        coef_addr  = 3'(lane);
        coef_wdata = 14'(val);
        if (m_idle) coef_m[lane] = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic zero_data();
        for (int c = 0; c < NCELL; c++) est_m[c] = 0;
        for (int m = 0; m < NLANE; m++) begin
            sym_m[m]  = 0;
            shat_m[m] = 0;
        end
    endtask

    task automatic sweep_data(int k);
        for (int c = 0; c < NCELL; c++) est_m[c] = ((k * 37 + c * 101) % 3000) - 1500;
        for (int m = 0; m < NLANE; m++) begin
            sym_m[m]  = (2 * ((k * 53 + m * 29) % 8) - 7) * 128;
            shat_m[m] = ((k * 71 + m * 13) % 1800) - 900;
        end
    endtask

    // Scoreboard: sampled 2 ns after the falling edge.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (rp == wp) begin
                check(1'b0, "R7 unexpected output", 1, 0);
            end else begin
                bit ok;
                int bad_c;
                ok = 1'b1;
                bad_c = 0;
                for (int c = 0; c < NCELL; c++)
                    if (int'($signed(center_o[c*DW +: DW])) != exp_c[rp % QD][c] && ok) begin
                        ok = 1'b0;
                        bad_c = c;
                    end
                check(ok, exp_r[rp % QD], int'($signed(center_o[bad_c*DW +: DW])),
                      exp_c[rp % QD][bad_c]);
                if (exp_lat[rp % QD])
                    check(cyc == exp_cy[rp % QD], "R7 latency", cyc, exp_cy[rp % QD]);
                rp++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < NLANE; m++) coef_m[m] = 0;
        zero_data();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state.
        check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
        sweep_data(5);
        send(1'b1, "R9 zero coef", 1'b1);

        // Load distinct lane ratios.
        wr_coef(0, 64);  wr_coef(1, -160); wr_coef(2, 256);
        wr_coef(3, 38);  wr_coef(4, -90);  wr_coef(5, 141);

        // R1 then R4: every owner code, streamed back to back.
        for (int k = 0; k < 64; k++) begin
            cfg_m = k;
            sweep_data(k);
            send(1'b1, (k < 8) ? "R1 center" : "R4 routing", 1'b1);
        end

        // R2: rounding sweep on lane 0 only.
        for (int m = 0; m < NLANE; m++) wr_coef(m, 0);
        wr_coef(0, 1);
        cfg_m = 0;
        zero_data();
        for (int d = -200; d <= 200; d++) begin
            sym_m[0] = d;
            send(1'b1, "R2 rounding", 1'b1);
        end
        // R2: offset saturation before the product.
        wr_coef(0, 64);
        sym_m[0] = 8191; shat_m[0] = -8192;
        send(1'b1, "R2 offset clip", 1'b1);
        // R3: center saturation both ways.
        wr_coef(0, 8191);
        est_m[0] = -8192;
        send(1'b1, "R3 low clip", 1'b1);
        wr_coef(0, -8192);
        est_m[0] = 8191;
        send(1'b1, "R3 high clip", 1'b1);

        // R6: configuration frozen within a vector.
        wr_coef(0, 64); wr_coef(1, -160); wr_coef(2, 256);
        wr_coef(3, 38); wr_coef(4, -90);  wr_coef(5, 141);
        sweep_data(7);
        cfg_m = 0;       send(1'b0, "R6 first", 1'b1);
        cfg_m = 6'h2A;   sweep_data(8); send(1'b0, "R6 mid", 1'b1);
        cfg_m = 6'h15;   sweep_data(9); send(1'b1, "R6 last", 1'b1);
        cfg_m = 6'h2A;   sweep_data(10); send(1'b1, "R6 next vector", 1'b1);

        // R5: write ignored while a vector is open, honoured when idle.
        cfg_m = 0;
        sweep_data(11);
        send(1'b0, "R5 open", 1'b1);
        wr_coef(0, 500);
        send(1'b1, "R5 ignored write", 1'b1);
        send(1'b1, "R5 old value", 1'b1);
        wr_coef(0, 500);
        send(1'b1, "R5 new value", 1'b1);

        // R8: back-pressure.
        repeat (3) @(negedge clk);
        out_ready = 1'b0;
        sweep_data(12); send(1'b1, "R8 first", 1'b0);
        sweep_data(13); send(1'b1, "R8 second", 1'b0);
        begin
            logic [NCELL*DW-1:0] held;
            held = center_o;
            for (int i = 0; i < 3; i++) begin
                check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
                check(in_ready == 1'b0, "R8 ready low", int'(in_ready), 0);
                check(center_o == held, "R8 data held", int'(center_o[DW-1:0]), int'(held[DW-1:0]));
                @(negedge clk);
            end
        end
        out_ready = 1'b1;

        // Drain.
        for (int i = 0; i < 20 && rp != wp; i++) @(negedge clk);
        check(rp == wp, "R7 all results delivered", rp, wp);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule